// File: doc/BRIEF.md
# Write-Back Write-Allocate Direct-Mapped Cache Controller

This block sits between a processor and main memory and holds 1024 single-word lines. Each line keeps a valid flag, a modified flag, a 20-bit tag and one 32-bit data word. The processor issues one load or store at a time through a request/accept handshake. The block answers with a one-cycle completion pulse that carries the line's word.

A hit is served from the cache array alone, and a store hit only marks the line as modified. On a miss, the line occupying the slot is copied out to memory first if it is valid and modified. The requested word is then read in. A store is merged into the freshly loaded line afterwards, so one processor access costs zero, one or two memory transactions. Memory requests are held steady until the memory acknowledges them.

Top module: `cacheTop`

## Requirements
- R1: The address splits into a tag in bits [31:12], a line index in bits [11:2] and a byte offset in bits [1:0]. The byte offset is ignored, so two addresses that differ only in bits [1:0] select the same word. Every memory request address has bits [1:0] equal to zero.
- R2: A load whose tag matches a valid line returns that line's word and issues no memory transaction.
- R3: A store that hits updates only the cached word and marks the line modified. Memory keeps its old value and no memory transaction is issued.
- R4: A miss whose slot is invalid or unmodified issues exactly one memory read at {tag, index, 2'b00}. A load then returns the word read.
- R5: A miss whose slot holds a valid modified line first writes that line's word to {stored tag, index, 2'b00}. It then issues the read: two transactions, the write before the read.
- R6: A store miss reads the block first and then merges the store data. The line ends modified, so its next eviction writes the stored value back.
- R7: A refill leaves the line unmodified. After a load miss, evicting that line again costs one read and no write.
- R8: Reset clears every valid and modified flag. After reset the first access to any line misses without a write-back, and the block is ready with no memory request pending.
- R9: cpuReady is high only while the block is idle. Each accepted request produces exactly one single-cycle cpuDone. A memory request keeps memReq, memWe and memAddr stable until memAck.
- R10: Lines at different indices are independent, including index 0 and index 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor request valid |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | 32 | Processor byte address |
| cpuWdata | input | 32 | Store data |
| cpuReady | output | 1 | Block idle; a request is accepted when cpuReq and cpuReady are both high at a clock edge |
| cpuDone | output | 1 | One-cycle completion pulse |
| cpuRdata | output | 32 | Line word, valid while cpuDone is high |
| memReq | output | 1 | Memory transaction request |
| memWe | output | 1 | 1 = write-back, 0 = refill read |
| memAddr | output | 32 | Word-aligned memory address |
| memWdata | output | 32 | Write-back data |
| memAck | input | 1 | Memory completion, one cycle |
| memRdata | input | 32 | Refill data, valid with memAck |

## Verification
The hardest situation to create from the ports is a store miss landing on a slot that already holds a modified line. Reaching it needs a write-back, a refill and a merge in one access, and the merged value is only visible once that line is evicted again. The stimulus confines tags to four values and indices to a narrow band plus the top few lines, so random stores collide often. Directed sequences cover the clean and dirty victim chains and the byte-offset aliasing. A final pass loads a conflicting tag into every modified line, and the memory image is then compared word for word with the reference.

// File: rtl/cachePkg.sv
package cachePkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COMPARE,
    ST_WRITEBACK,
    ST_ALLOCATE,
    ST_RESPOND
  } ctlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;   // capture processor request
    logic storeMerge; // write request data into the line, mark modified
    logic fillLine;   // install refill word, tag, valid, clear modified
    logic selVictim;  // memory address uses stored tag
  } dpCtl_t;
endpackage

// File: rtl/cacheDatapath.sv
module cacheDatapath
  import cachePkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWe,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              reqWe,
  output logic              lineHit,
  output logic              victimDirty,
  output logic [DATA_W-1:0] lineData,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memRdata
);
  localparam int IDX_W = $clog2(LINES);
  localparam int OFF_W = $clog2(DATA_W / 8);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  logic [TAG_W-1:0]  reqTag;
  logic [IDX_W-1:0]  reqIdx;
  logic [DATA_W-1:0] reqWdata;
  logic              unusedOffset;

  logic [LINES-1:0]  validBits;
  logic [LINES-1:0]  dirtyBits;
  logic [TAG_W-1:0]  tagArr  [LINES];
  logic [DATA_W-1:0] dataArr [LINES];

  assign unusedOffset = ^cpuAddr[OFF_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqTag   <= '0;
      reqIdx   <= '0;
      reqWdata <= '0;
      reqWe    <= 1'b0;
    end else if (ctl.latchReq) begin
      reqTag   <= cpuAddr[ADDR_W-1 -: TAG_W];
      reqIdx   <= cpuAddr[OFF_W +: IDX_W];
      reqWdata <= cpuWdata;
      reqWe    <= cpuWe;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validBits <= '0;
      dirtyBits <= '0;
    end else if (ctl.fillLine) begin
      validBits[reqIdx] <= 1'b1;
      dirtyBits[reqIdx] <= 1'b0;
    end else if (ctl.storeMerge) begin
      dirtyBits[reqIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.fillLine) begin
      tagArr[reqIdx]  <= reqTag;
      dataArr[reqIdx] <= memRdata;
    end else if (ctl.storeMerge) begin
      dataArr[reqIdx] <= reqWdata;
    end
  end

  assign lineHit     = validBits[reqIdx] && (tagArr[reqIdx] == reqTag);
  assign victimDirty = validBits[reqIdx] && dirtyBits[reqIdx];
  assign lineData    = dataArr[reqIdx];
  assign memAddr     = {(ctl.selVictim ? tagArr[reqIdx] : reqTag), reqIdx, {OFF_W{1'b0}}};
endmodule

// File: rtl/cacheControl.sv
module cacheControl
  import cachePkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   cpuReq,
  input  logic   reqWe,
  input  logic   lineHit,
  input  logic   victimDirty,
  input  logic   memAck,
  output dpCtl_t ctl,
  output logic   cpuReady,
  output logic   cpuDone,
  output logic   memReq,
  output logic   memWe
);
  ctlState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    cpuReady  = 1'b0;
    cpuDone   = 1'b0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        cpuReady = 1'b1;
        if (cpuReq) begin
          ctl.latchReq = 1'b1;
          nextState    = ST_COMPARE;
        end
      end
      ST_COMPARE: begin
        if (lineHit) begin
          ctl.storeMerge = reqWe;
          nextState      = ST_RESPOND;
        end else if (victimDirty) begin
          nextState = ST_WRITEBACK;
        end else begin
          nextState = ST_ALLOCATE;
        end
      end
      ST_WRITEBACK: begin
        memReq        = 1'b1;
        memWe         = 1'b1;
        ctl.selVictim = 1'b1;
        if (memAck) nextState = ST_ALLOCATE;
      end
      ST_ALLOCATE: begin
        memReq = 1'b1;
        if (memAck) begin
          ctl.fillLine = 1'b1;
          nextState    = ST_COMPARE;
        end
      end
      ST_RESPOND: begin
        cpuDone   = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/cacheTop.sv
module cacheTop
  import cachePkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuReady,
  output logic              cpuDone,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata
);
  dpCtl_t            ctl;
  logic              reqWe;
  logic              lineHit;
  logic              victimDirty;
  logic [DATA_W-1:0] lineData;

  cacheControl u_ctl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .reqWe(reqWe),
    .lineHit(lineHit), .victimDirty(victimDirty), .memAck(memAck),
    .ctl(ctl), .cpuReady(cpuReady), .cpuDone(cpuDone),
    .memReq(memReq), .memWe(memWe)
  );

  cacheDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cpuAddr(cpuAddr), .cpuWe(cpuWe),
    .cpuWdata(cpuWdata), .reqWe(reqWe), .lineHit(lineHit),
    .victimDirty(victimDirty), .lineData(lineData), .memAddr(memAddr),
    .memRdata(memRdata)
  );

  assign cpuRdata = lineData;
  assign memWdata = lineData;
endmodule

// File: rtl/cacheChecker.sv
module cacheChecker #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReq,
  input logic              cpuReady,
  input logic              cpuDone,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memAck
);
  logic [IDX_W-1:0] seenIdx;

  always_ff @(posedge clk) begin
    if (!rstN) seenIdx <= '0;
    else if (cpuReq && cpuReady) seenIdx <= cpuAddr[OFF_W +: IDX_W];
  end

  AST_MEM_INDEX: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[OFF_W +: IDX_W] == seenIdx) && (memAddr[OFF_W-1:0] == '0)); // R1
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> memReq && $stable(memWe) && $stable(memAddr)); // R9
  AST_WB_THEN_READ: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && memAck) |=> memReq && !memWe); // R5
  AST_FILL_NO_MORE: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe && memAck) |=> !memReq); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |=> !cpuDone && cpuReady); // R9
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && cpuReady) |=> !cpuReady); // R9
  AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |-> !cpuReady && !memReq); // R9
endmodule

bind cacheTop cacheChecker #(.ADDR_W(ADDR_W), .IDX_W($clog2(LINES)), .OFF_W($clog2(DATA_W / 8))) u_chk (
  .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuReady(cpuReady), .cpuDone(cpuDone),
  .cpuAddr(cpuAddr), .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memAck(memAck)
);

// File: tb/cacheTop_tb.sv
module cacheTop_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuReq = 1'b0, cpuWe = 1'b0;
  logic [31:0] cpuAddr = '0, cpuWdata = '0;
  logic        cpuReady, cpuDone;
  logic [31:0] cpuRdata;
  logic        memReq, memWe;
  logic [31:0] memAddr, memWdata;
  logic        memAck = 1'b0;
  logic [31:0] memRdata = '0;

  int testCnt = 0, failCnt = 0;
  int rdCnt = 0, wrCnt = 0;
  int waitCnt = 0;
  bit finished = 0;

  logic [31:0] mainMem [4096];
  logic [31:0] refMem  [4096];
  bit          refValid [1024];
  bit          refDirty [1024];
  logic [19:0] refTag   [1024];

  always #2 clk = ~clk; // 250 MHz

  cacheTop u_dut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuReady(cpuReady), .cpuDone(cpuDone), .cpuRdata(cpuRdata),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata)
  );

  function automatic logic [31:0] initVal(int i);
    return (i * 32'h9E3779B1) ^ 32'h00A5_5A00;
  endfunction

  function automatic logic [31:0] mkAddr(int tag, int idx, int off);
    return {18'd0, tag[1:0], idx[9:0], off[1:0]};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model with 0..2 extra wait cycles
  always @(posedge clk) begin
    memAck <= 1'b0;
    if (rstN && memReq && !memAck) begin
      if (waitCnt == 0) begin
        memAck <= 1'b1;
        testCnt++;
        if (memAddr[31:14] != 0 || memAddr[1:0] != 0) begin
          failCnt++;
          $display("FAIL R1 memory address out of range: actual %h expected upper/low bits zero", memAddr);
        end
        if (memWe) begin
          mainMem[memAddr[13:2]] <= memWdata;
          wrCnt <= wrCnt + 1;
        end else begin
          memRdata <= mainMem[memAddr[13:2]];
          rdCnt <= rdCnt + 1;
        end
        waitCnt <= int'($urandom % 3);
      end else begin
        waitCnt <= waitCnt - 1;
      end
    end
  end

  task automatic doAcc(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                       output logic [31:0] rd, output int nR, output int nW);
    int r0, w0;
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = addr; cpuWdata = wd;
    while (!cpuReady) @(negedge clk);
    r0 = rdCnt; w0 = wrCnt;
    @(negedge clk);
    cpuReq = 1'b0;
    while (!cpuDone) @(negedge clk);
    rd = cpuRdata; nR = rdCnt - r0; nW = wrCnt - w0;
  endtask

  // reference: architectural memory plus slot state per the requirements
  task automatic refAcc(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                        output logic [31:0] expD, output int eR, output int eW);
    int idx, w;
    idx = int'(addr[11:2]); w = int'(addr[13:2]);
    if (refValid[idx] && refTag[idx] == addr[31:12]) begin
      eR = 0; eW = 0;
    end else begin
      eW = (refValid[idx] && refDirty[idx]) ? 1 : 0;
      eR = 1;
      refValid[idx] = 1; refTag[idx] = addr[31:12]; refDirty[idx] = 0;
    end
    if (we) begin
      refMem[w] = wd;
      refDirty[idx] = 1;
    end
    expD = refMem[w];
  endtask

  task automatic run(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                     input string req, output logic [31:0] rd);
    logic [31:0] expD;
    int eR, eW, nR, nW;
    refAcc(we, addr, wd, expD, eR, eW);
    doAcc(we, addr, wd, rd, nR, nW);
    chk(nR == eR, req, "memory reads", 32'(nR), 32'(eR));
    chk(nW == eW, req, "memory writes", 32'(nW), 32'(eW));
    if (!we) chk(rd == expD, req, "load data", rd, expD);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testCnt + 1, failCnt);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int seedDummy, mism;
    seedDummy = int'($urandom(32'h1234_5678));
    for (int i = 0; i < 4096; i++) begin mainMem[i] = initVal(i); refMem[i] = initVal(i); end
    for (int i = 0; i < 1024; i++) begin refValid[i] = 0; refDirty[i] = 0; refTag[i] = '0; end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(cpuReady == 1'b1, "R8", "ready after reset", 32'(cpuReady), 32'd1);
    chk(memReq == 1'b0, "R8", "no memory request after reset", 32'(memReq), 32'd0);

    // R8/R4: first access misses with one read, no write-back
    run(1'b0, mkAddr(0, 5, 0), '0, "R8", rd);
    // R1/R2: offset alias hits
    run(1'b0, mkAddr(0, 5, 1), '0, "R1", rd);
    // R3: store hit, memory stays stale
    run(1'b1, mkAddr(0, 5, 2), 32'hDEAD_BEEF, "R3", rd);
    chk(mainMem[5] == initVal(5), "R3", "memory stale after store hit", mainMem[5], initVal(5));
    run(1'b0, mkAddr(0, 5, 3), '0, "R2", rd);
    // R5: dirty victim written back then read
    run(1'b0, mkAddr(1, 5, 0), '0, "R5", rd);
    chk(mainMem[5] == 32'hDEAD_BEEF, "R5", "written-back word", mainMem[5], 32'hDEAD_BEEF);
    // R7: refilled line is clean
    run(1'b0, mkAddr(2, 5, 0), '0, "R7", rd);
    // R6: store miss allocates, merges, later eviction writes it
    run(1'b1, mkAddr(3, 7, 0), 32'h1357_9BDF, "R6", rd);
    run(1'b0, mkAddr(3, 7, 0), '0, "R6", rd);
    run(1'b0, mkAddr(0, 7, 0), '0, "R6", rd);
    chk(mainMem[{2'd3, 10'd7}] == 32'h1357_9BDF, "R6", "merged store written back",
        mainMem[{2'd3, 10'd7}], 32'h1357_9BDF);
    // R10: extreme indices independent
    run(1'b1, mkAddr(1, 0, 0), 32'h0000_0A0A, "R10", rd);
    run(1'b1, mkAddr(1, 1023, 0), 32'h0000_0B0B, "R10", rd);
    run(1'b0, mkAddr(1, 0, 0), '0, "R10", rd);
    run(1'b0, mkAddr(1, 1023, 0), '0, "R10", rd);

    // constrained random mix: four tags, narrow index band plus top lines
    for (int n = 0; n < 3000; n++) begin
      int tag, idx, off;
      logic we;
      tag = int'($urandom % 4);
      idx = ($urandom % 8 == 0) ? 1023 - int'($urandom % 4) : int'($urandom % 32);
      off = int'($urandom % 4);
      we  = logic'($urandom % 2);
      run(we, mkAddr(tag, idx, off), $urandom, "R4", rd);
    end

    // final forced eviction of every modified line
    for (int i = 0; i < 1024; i++) begin
      if (refValid[i] && refDirty[i])
        run(1'b0, mkAddr(int'((refTag[i] + 20'd1) & 20'd3), i, 0), '0, "R5", rd);
    end
    mism = 0;
    for (int i = 0; i < 4096; i++) if (mainMem[i] != refMem[i]) mism++;
    chk(mism == 0, "R5", "memory image mismatches after flush", 32'(mism), 32'd0);

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end
endmodule